// File: doc/BRIEF.md
# Dual-Bank Vectored Interrupt Controller

This block gathers sixty-four interrupt lines into two outputs for a processor: a normal request (IRQ) and a fast request (FIQ). The sources are split into a low bank (sources 0 to 31) and a high bank (sources 32 to 63). Source n sits in bank n>>5 at bit n&31. Each source can be level or edge sensitive, and its active level or edge is programmable. Edge events are held in latches until software clears them. A source can also be forced by software through a trigger bit. An enable mask gates each source, and a route bit steers it to IRQ or FIQ.

Software works through a 32-bit register port. The low-bank and high-bank words of each register are interleaved at a 4-byte spacing, so bit 2 of the address picks the bank. Enable and trigger are changed through separate write-one set and clear registers, so no read-modify-write is needed. Software finds the active source by reading the IRQ status words and taking the lowest set bit, low bank first.

Top module: `dualbank_intc`

## Requirements
- R1: After reset, every enable, trigger, route and latch bit is 0. Every level bit and every polarity bit is 1 (level, active high). Raw status reads 0 when the inputs are low, and `irq_o` and `fiq_o` are 0.
- R2: Address bit 2 selects the bank (0 low, 1 high) and bits 7:3 select the register. The registers are: 0 IRQ status, 1 FIQ status, 2 raw status, 3 route, 4 enable-set, 5 enable-clear, 6 trigger-set, 7 trigger-clear, 8 level-mode, 9 both-edges, 10 polarity, 11 edge-clear, 12 edge status. The low-bank byte offsets are 0x00, 0x08, ..., 0x60. An access with address bits 1:0 not zero writes nothing and reads 0. A read of an unmapped index or of edge-clear returns 0.
- R3: Writing 1s to enable-set sets those enable bits, and writing 1s to enable-clear clears them. Zero bits leave the state unchanged. Reading either offset returns the current enables.
- R4: Trigger-set and trigger-clear act on the trigger bits in the same write-one way as R3. A set trigger bit makes the source pending whatever its input.
- R5: A route bit of 0 sends an enabled pending source to IRQ, and a route bit of 1 sends it to FIQ.
- R6: A level-mode bit of 1 makes the source level sensitive, with nothing latched. A polarity bit of 1 means active high and 0 means active low.
- R7: A level-mode bit of 0 makes the source edge sensitive. With its both-edges bit at 1, a rising or a falling input edge sets the latch. Otherwise polarity 1 latches rising edges and polarity 0 latches falling edges. The latch holds after the input returns.
- R8: Writing 1s to edge-clear clears those edge latches. This has no effect on level sources. An edge detected in the same cycle as the clear write sets the latch again, so the new event is kept.
- R9: Raw status is the active level or the latch, ORed with the trigger. IRQ status is raw AND enable AND NOT route. FIQ status is raw AND enable AND route. Edge status is the latch contents.
- R10: `irq_o` is the OR of all 64 IRQ status bits and `fiq_o` is the OR of all 64 FIQ status bits. Both are registered and follow status one cycle later.
- R11: Read data is registered. It appears the cycle after `reg_rd` and shows the state from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| src_in | input | 64 | Raw interrupt inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two things can meet in one cycle. The first is an input edge on a source and a write to edge-clear for that same source. The bench changes the input on the same clock edge as the clear write and then expects the latch to still be set. The second is a read and a write to the same register in one cycle. The bench expects the read to return the value from before the write, and a second read to show the new value. A behavioural model in the bench tracks both outputs on every clock and gives the expected value for every register read.

// File: rtl/dbi_pkg.sv
`timescale 1ns/1ps
package dbi_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned ADDR_W    = 8;

  // Register index taken from address bits 7:3.
  typedef enum logic [4:0] {
    IDX_IRQ_ST   = 5'd0,
    IDX_FIQ_ST   = 5'd1,
    IDX_RAW      = 5'd2,
    IDX_ROUTE    = 5'd3,
    IDX_EN_SET   = 5'd4,
    IDX_EN_CLR   = 5'd5,
    IDX_TRG_SET  = 5'd6,
    IDX_TRG_CLR  = 5'd7,
    IDX_LEVEL    = 5'd8,
    IDX_BOTH     = 5'd9,
    IDX_POL      = 5'd10,
    IDX_EDGE_CLR = 5'd11,
    IDX_EDGE_ST  = 5'd12
  } reg_idx_e;
endpackage

// File: rtl/dbi_rst_sync.sv
`timescale 1ns/1ps
module dbi_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dbi_edge_det.sv
`timescale 1ns/1ps
module dbi_edge_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] active_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  assign rise = src_i & ~prev_q;
  assign fall = ~src_i & prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign active_o[i] = pol_i[i] ? src_i[i] : ~src_i[i];
    assign hit_o[i]    = level_i[i] ? 1'b0 :
                         both_i[i]  ? (rise[i] | fall[i]) :
                         pol_i[i]   ? rise[i] : fall[i];
  end
endmodule

// File: rtl/dbi_bank.sv
`timescale 1ns/1ps
module dbi_bank
  import dbi_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  reg_idx_e     idx_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] route_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] trg_o,
  output logic [W-1:0] level_o,
  output logic [W-1:0] both_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] irq_st_o,
  output logic [W-1:0] fiq_st_o
);
  logic [W-1:0] route_q, route_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] trg_q, trg_d;
  logic [W-1:0] level_q, level_d;
  logic [W-1:0] both_q, both_d;
  logic [W-1:0] pol_q, pol_d;
  logic [W-1:0] latch_q, latch_d;
  logic [W-1:0] clr_mask;
  logic [W-1:0] hit;
  logic [W-1:0] active;
  logic         cfg_ld;

  dbi_edge_det #(.W(W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .level_i  (level_q),
    .both_i   (both_q),
    .pol_i    (pol_q),
    .hit_o    (hit),
    .active_o (active)
  );

  assign cfg_ld = wr_i;

  always_comb begin
    route_d  = route_q;
    en_d     = en_q;
    trg_d    = trg_q;
    level_d  = level_q;
    both_d   = both_q;
    pol_d    = pol_q;
    clr_mask = '0;
    if (wr_i) begin
      case (idx_i)
        IDX_ROUTE:    route_d  = wdata_i;
        IDX_EN_SET:   en_d     = en_q | wdata_i;
        IDX_EN_CLR:   en_d     = en_q & ~wdata_i;
        IDX_TRG_SET:  trg_d    = trg_q | wdata_i;
        IDX_TRG_CLR:  trg_d    = trg_q & ~wdata_i;
        IDX_LEVEL:    level_d  = wdata_i;
        IDX_BOTH:     both_d   = wdata_i;
        IDX_POL:      pol_d    = wdata_i;
        IDX_EDGE_CLR: clr_mask = wdata_i;
        default:      ;
      endcase
    end
    // A fresh edge is kept even if a clear lands on it in the same cycle.
    latch_d = ((latch_q & ~clr_mask) | hit) & ~level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      en_q    <= '0;
      trg_q   <= '0;
      level_q <= '1;
      both_q  <= '0;
      pol_q   <= '1;
    end else if (cfg_ld) begin
      route_q <= route_d;
      en_q    <= en_d;
      trg_q   <= trg_d;
      level_q <= level_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign raw_o    = (level_q & active) | (~level_q & latch_q) | trg_q;
  assign irq_st_o = raw_o & en_q & ~route_q;
  assign fiq_st_o = raw_o & en_q & route_q;

  assign route_o = route_q;
  assign en_o    = en_q;
  assign trg_o   = trg_q;
  assign level_o = level_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/dbi_rdmux.sv
`timescale 1ns/1ps
module dbi_rdmux
  import dbi_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned N = NUM_BANKS * W
) (
  input  reg_idx_e     idx_i,
  input  logic         bank_i,
  input  logic [N-1:0] irq_st_i,
  input  logic [N-1:0] fiq_st_i,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] route_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] trg_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] latch_i,
  output logic [W-1:0] word_o
);
  logic [N-1:0] vec;

  always_comb begin
    case (idx_i)
      IDX_IRQ_ST:              vec = irq_st_i;
      IDX_FIQ_ST:              vec = fiq_st_i;
      IDX_RAW:                 vec = raw_i;
      IDX_ROUTE:               vec = route_i;
      IDX_EN_SET, IDX_EN_CLR:  vec = en_i;
      IDX_TRG_SET, IDX_TRG_CLR: vec = trg_i;
      IDX_LEVEL:               vec = level_i;
      IDX_BOTH:                vec = both_i;
      IDX_POL:                 vec = pol_i;
      IDX_EDGE_ST:             vec = latch_i;
      default:                 vec = '0;
    endcase
    word_o = bank_i ? vec[W +: W] : vec[0 +: W];
  end
endmodule

// File: rtl/dualbank_intc.sv
`timescale 1ns/1ps
module dualbank_intc
  import dbi_pkg::*;
#(
  parameter int unsigned BANK_W = 32,
  localparam int unsigned NSRC = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_o,
  output logic              fiq_o
);
  logic              rst_s_n;
  logic              addr_ok;
  logic              bank_sel;
  reg_idx_e          idx;
  logic [NSRC-1:0]   route_all, en_all, trg_all, level_all, both_all, pol_all;
  logic [NSRC-1:0]   latch_all, raw_all, irq_st_all, fiq_st_all;
  logic [BANK_W-1:0] rd_word;
  logic [BANK_W-1:0] rdata_q, rdata_d;
  logic              irq_q, fiq_q;

  dbi_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_s_n)
  );

  assign addr_ok  = (reg_addr[1:0] == 2'b00);
  assign bank_sel = reg_addr[2];
  assign idx      = reg_idx_e'(reg_addr[7:3]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbi_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .wr_i     (reg_wr & addr_ok & (bank_sel == 1'(b))),
      .idx_i    (idx),
      .wdata_i  (reg_wdata),
      .src_i    (src_in[b*BANK_W +: BANK_W]),
      .route_o  (route_all[b*BANK_W +: BANK_W]),
      .en_o     (en_all[b*BANK_W +: BANK_W]),
      .trg_o    (trg_all[b*BANK_W +: BANK_W]),
      .level_o  (level_all[b*BANK_W +: BANK_W]),
      .both_o   (both_all[b*BANK_W +: BANK_W]),
      .pol_o    (pol_all[b*BANK_W +: BANK_W]),
      .latch_o  (latch_all[b*BANK_W +: BANK_W]),
      .raw_o    (raw_all[b*BANK_W +: BANK_W]),
      .irq_st_o (irq_st_all[b*BANK_W +: BANK_W]),
      .fiq_st_o (fiq_st_all[b*BANK_W +: BANK_W])
    );
  end

  dbi_rdmux #(.W(BANK_W)) u_rdmux (
    .idx_i    (idx),
    .bank_i   (bank_sel),
    .irq_st_i (irq_st_all),
    .fiq_st_i (fiq_st_all),
    .raw_i    (raw_all),
    .route_i  (route_all),
    .en_i     (en_all),
    .trg_i    (trg_all),
    .level_i  (level_all),
    .both_i   (both_all),
    .pol_i    (pol_all),
    .latch_i  (latch_all),
    .word_o   (rd_word)
  );

  always_comb begin
    rdata_d = addr_ok ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |irq_st_all;
      fiq_q <= |fiq_st_all;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign fiq_o     = fiq_q;
endmodule

// File: rtl/dbi_chk.sv
`timescale 1ns/1ps
module dbi_chk #(
  parameter int unsigned BANK_W = 32,
  parameter int unsigned NSRC   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [7:0]        reg_addr,
  input logic [BANK_W-1:0] reg_wdata,
  input logic [BANK_W-1:0] reg_rdata,
  input logic [NSRC-1:0]   en_all,
  input logic [NSRC-1:0]   latch_all,
  input logic [NSRC-1:0]   level_all,
  input logic [NSRC-1:0]   irq_st_all,
  input logic [NSRC-1:0]   fiq_st_all,
  input logic              irq_o,
  input logic              fiq_o
);
  logic [NSRC-1:0] wmask;
  logic            aligned;

  assign wmask   = reg_addr[2] ? {reg_wdata, {BANK_W{1'b0}}} : {{BANK_W{1'b0}}, reg_wdata};
  assign aligned = (reg_addr[1:0] == 2'b00);

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && aligned && reg_addr[7:3] == 5'd4) |=> ((en_all & $past(wmask)) == $past(wmask)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && aligned && reg_addr[7:3] == 5'd5) |=> ((en_all & $past(wmask)) == '0));

  // R8
  lvl_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_all & level_all) == '0));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_st_all) |=> irq_o);

  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_st_all) |=> !irq_o);

  // R10
  fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fiq_st_all) |=> fiq_o);

  // R2
  misalign_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !aligned) |=> (reg_rdata == '0));
endmodule

bind dualbank_intc dbi_chk #(.BANK_W(BANK_W), .NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .en_all     (en_all),
  .latch_all  (latch_all),
  .level_all  (level_all),
  .irq_st_all (irq_st_all),
  .fiq_st_all (fiq_st_all),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o)
);

// File: tb/sim_dualbank_intc.sv
`timescale 1ns/1ps
module sim_dualbank_intc;
  localparam logic [7:0] A_IRQ = 8'h00, A_FIQ = 8'h08, A_RAW = 8'h10, A_SEL = 8'h18;
  localparam logic [7:0] A_ENS = 8'h20, A_ENC = 8'h28, A_TS = 8'h30, A_TC = 8'h38;
  localparam logic [7:0] A_LVL = 8'h40, A_BOTH = 8'h48, A_POL = 8'h50, A_ECLR = 8'h58;
  localparam logic [7:0] A_EST = 8'h60, HI = 8'h04;

  logic        clk, rst_n, reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] src_in;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  bit live  = 0;

  dualbank_intc u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference model.
  logic [63:0] m_en, m_trg, m_sel, m_lvl, m_both, m_pol, m_lat, m_prev;
  logic [63:0] m_raw, m_det, m_clr, m_wm, m_bm, m_v;
  logic        m_irq, m_fiq;
  logic [31:0] m_rd;
  int          m_b, m_k;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_trg = '0; m_sel = '0; m_lvl = '1; m_both = '0; m_pol = '1;
      m_lat = '0; m_prev = '0; m_irq = 0; m_fiq = 0; m_rd = '0;
    end else begin
      for (int i = 0; i < 64; i++) begin
        bit act, r, f;
        act = m_pol[i] ? src_in[i] : !src_in[i];
        r = src_in[i] && !m_prev[i];
        f = !src_in[i] && m_prev[i];
        m_raw[i] = (m_lvl[i] ? act : m_lat[i]) | m_trg[i];
        m_det[i] = !m_lvl[i] && (m_both[i] ? (r || f) : (m_pol[i] ? r : f));
      end
      m_b = int'(reg_addr[2]);
      m_k = int'(reg_addr[7:3]);
      if (reg_rd) begin
        case (m_k)
          0: m_v = m_raw & m_en & ~m_sel;
          1: m_v = m_raw & m_en & m_sel;
          2: m_v = m_raw;
          3: m_v = m_sel;
          4, 5: m_v = m_en;
          6, 7: m_v = m_trg;
          8: m_v = m_lvl;
          9: m_v = m_both;
          10: m_v = m_pol;
          12: m_v = m_lat;
          default: m_v = '0;
        endcase
        m_rd = (reg_addr[1:0] != 2'b00) ? 32'h0 : m_v[32*m_b +: 32];
      end
      m_irq = |(m_raw & m_en & ~m_sel);
      m_fiq = |(m_raw & m_en & m_sel);
      m_wm = '0; m_bm = '0; m_clr = '0;
      if (reg_wr && reg_addr[1:0] == 2'b00) begin
        m_wm[32*m_b +: 32] = reg_wdata;
        m_bm[32*m_b +: 32] = 32'hffff_ffff;
        if (m_k == 11) m_clr = m_wm;
      end
      m_lat = ((m_lat & ~m_clr) | m_det) & ~m_lvl;
      if (reg_wr && reg_addr[1:0] == 2'b00) begin
        case (m_k)
          3: m_sel = (m_sel & ~m_bm) | m_wm;
          4: m_en = m_en | m_wm;
          5: m_en = m_en & ~m_wm;
          6: m_trg = m_trg | m_wm;
          7: m_trg = m_trg & ~m_wm;
          8: m_lvl = (m_lvl & ~m_bm) | m_wm;
          9: m_both = (m_both & ~m_bm) | m_wm;
          10: m_pol = (m_pol & ~m_bm) | m_wm;
          default: ;
        endcase
      end
      m_prev = src_in;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Outputs compared with the model on every clock (R10, R5).
  always @(negedge clk) begin
    if (live) begin
      chk("R10 irq_o", {31'b0, irq_o}, {31'b0, m_irq});
      chk("R10 fiq_o", {31'b0, fiq_o}, {31'b0, m_fiq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdx(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
    chk(req, reg_rdata, m_rd);
    chk(req, reg_rdata, exp);
  endtask

  task automatic setsrc(input int n, input logic v);
    @(negedge clk); src_in[n] = v;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0; src_in = '0;
    wait_n(3);
    rst_n = 1;
    wait_n(3);
    live = 1;

    // R1 reset state
    chk("R1 irq_o reset", {31'b0, irq_o}, 32'h0);
    rdx(A_LVL, 32'hffff_ffff, "R1 level lo");
    rdx(A_LVL | HI, 32'hffff_ffff, "R1 level hi");
    rdx(A_POL, 32'hffff_ffff, "R1 pol");
    rdx(A_ENS, 32'h0, "R1 enable");
    rdx(A_RAW | HI, 32'h0, "R1 raw");

    // R3 enable set/clear
    wr(A_ENS, 32'h9);
    rdx(A_ENS, 32'h9, "R3 set");
    wr(A_ENS, 32'h0);
    rdx(A_ENC, 32'h9, "R3 zero set no effect");
    wr(A_ENC, 32'h1);
    rdx(A_ENS, 32'h8, "R3 clear");
    wr(A_ENC, 32'h0);
    rdx(A_ENS, 32'h8, "R3 zero clear no effect");

    // R6 level, active high
    setsrc(3, 1); wait_n(2);
    chk("R6 level high irq", {31'b0, irq_o}, 32'h1);
    rdx(A_IRQ, 32'h8, "R9 irq status");
    setsrc(3, 0); wait_n(2);
    chk("R6 level released", {31'b0, irq_o}, 32'h0);

    // R6 active low in high bank, R2 bank addressing, R5 routing
    wr(A_POL | HI, ~(32'h100));
    rdx(A_RAW | HI, 32'h100, "R6 active low raw");
    wr(A_ENS | HI, 32'h100); wait_n(2);
    chk("R5 route irq", {31'b0, irq_o}, 32'h1);
    wr(A_SEL | HI, 32'h100); wait_n(2);
    chk("R5 route fiq", {31'b0, fiq_o}, 32'h1);
    chk("R5 irq dropped", {31'b0, irq_o}, 32'h0);
    rdx(A_FIQ | HI, 32'h100, "R5 fiq status");
    rdx(A_IRQ | HI, 32'h0, "R5 irq status");
    setsrc(40, 1); wait_n(2);
    chk("R6 inactive high", {31'b0, fiq_o}, 32'h0);

    // R4 soft trigger
    wr(A_TS, 32'h400);
    rdx(A_RAW, 32'h400, "R4 trigger raw");
    rdx(A_IRQ, 32'h0, "R4 masked");
    wr(A_ENS, 32'h400); wait_n(2);
    chk("R4 trigger irq", {31'b0, irq_o}, 32'h1);
    wr(A_TC, 32'h400);
    rdx(A_RAW, 32'h0, "R4 trigger cleared");

    // R7 edge modes: 12 rising, 13 falling, 14 both
    wr(A_LVL, ~(32'h7000));
    wr(A_POL, ~(32'h2000));
    wr(A_BOTH, 32'h4000);
    setsrc(12, 1); setsrc(12, 0);
    rdx(A_EST, 32'h1000, "R7 rising latched");
    setsrc(13, 1);
    rdx(A_EST, 32'h1000, "R7 falling ignores rise");
    setsrc(13, 0);
    rdx(A_EST, 32'h3000, "R7 falling latched");
    setsrc(14, 1);
    rdx(A_EST, 32'h7000, "R7 both rise");
    wr(A_ENS, 32'h1000); wait_n(2);
    chk("R7 latch holds irq", {31'b0, irq_o}, 32'h1);

    // R8 edge clear
    wr(A_ECLR, 32'h1000);
    rdx(A_EST, 32'h6000, "R8 clear");
    wait_n(1);
    chk("R8 irq after clear", {31'b0, irq_o}, 32'h0);
    setsrc(3, 1);
    wr(A_ECLR, 32'h8); wait_n(1);
    rdx(A_RAW, 32'h6008, "R8 level unaffected");
    chk("R8 level irq kept", {31'b0, irq_o}, 32'h1);
    setsrc(3, 0);
    // same-cycle edge on 14 (falling, both edges) and clear of 14
    @(negedge clk); reg_wr = 1; reg_addr = A_ECLR; reg_wdata = 32'h4000; src_in[14] = 0;
    @(negedge clk); reg_wr = 0;
    rdx(A_EST, 32'h6000, "R8 edge beats clear");
    wr(A_ECLR, 32'h6000);
    rdx(A_EST, 32'h0, "R8 clear all");

    // R11 read with same-cycle write
    @(negedge clk); reg_wr = 1; reg_rd = 1; reg_addr = A_ENS | HI; reg_wdata = 32'h8000_0000;
    @(negedge clk); reg_wr = 0; reg_rd = 0;
    chk("R11 old value", reg_rdata, 32'h100);
    chk("R11 model", reg_rdata, m_rd);
    rdx(A_ENS | HI, 32'h8000_0100, "R11 new value");

    // R2 misaligned and unmapped
    wr(A_ENS | 8'h01, 32'hffff_ffff);
    rdx(A_ENS, 32'h1408, "R2 misaligned write ignored");
    rdx(8'h01, 32'h0, "R2 misaligned read");
    rdx(8'h68, 32'h0, "R2 unmapped read");
    rdx(A_ECLR, 32'h0, "R2 edge clear reads zero");

    // R9 high bank trigger on bit 63 routed to FIQ
    wr(A_SEL | HI, 32'h8000_0100);
    wr(A_TS | HI, 32'h8000_0000); wait_n(1);
    rdx(A_FIQ | HI, 32'h8000_0000, "R9 fiq status hi");
    chk("R9 fiq out", {31'b0, fiq_o}, 32'h1);

    wait_n(4);
    done = 1;
    finish_up();
  end
endmodule